// File: doc/BRIEF.md
# Thread Group Barrier Unit

This unit coordinates barrier waits for several groups of threads that share one processor. The scheduler first launches a group by loading how many threads it holds. The number may be anything from one up to the largest group the unit supports, which is 512 threads by default. Each thread that reaches a barrier sends one arrival strobe, tagged with its group and its index inside that group. The unit counts the arrivals for the group and raises that thread's bit in a waiting bitmap. The scheduler reads the bitmap and does not issue any thread whose bit is set.

When the last missing thread of a group arrives, the unit does not mark it. In the next cycle it clears every waiting bit of the group and raises a one-cycle release pulse tagged with the group. The group's arrival count returns to zero at the same clock edge, so the barrier can be used again straight away, for example on every pass of a loop.

Arrivals that cannot be honoured are dropped and flagged. These are a thread that is already waiting, a thread index outside the group, and a group that was never launched. A launch with an unusable size is refused and flagged in the same way.

Top module: `barrier_unit`

## Requirements
- R1: After reset every waiting bit is 0, no group is launched, and releaseValid, arriveError and launchError are all 0.
- R2: A launch with launchCount from 1 to 512 (plain binary) sets that group's size, clears its arrival count and clears all of its waiting bits from the next cycle.
- R3: A launch with launchCount equal to 0 or above 512 gives launchError = 1 for exactly the next cycle and leaves the group's size, count and waiting bits unchanged.
- R4: An accepted arrival that does not complete its group sets waitMask bit (group*512 + thread) from the next cycle. That bit stays set until the group is released or launched again.
- R5: The arrival that brings a group's count up to its size gives, in the next cycle, releaseValid = 1 for exactly one cycle with releaseGroup equal to that group. All of that group's waiting bits read 0 in that same cycle.
- R6: The release returns the count to zero at the same edge, so an arrival in the cycle straight after a release starts a new round of that barrier.
- R7: An arrival from a thread whose waiting bit is already set does not add to the count and gives arriveError = 1 for the next cycle.
- R8: An arrival with a thread index not below the group's size, or to a group that has not been launched, changes nothing and gives arriveError = 1 for the next cycle.
- R9: Arrivals and releases of one group never change the waiting bits, count or release of any other group.
- R10: When a valid launch and an arrival name the same group in the same cycle, the launch takes effect and the arrival is dropped without an error.
- R11: A group of the full 512 threads releases only after all 512 distinct threads have arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| launchValid | input | 1 | Load a group size this cycle |
| launchGroup | input | 1 | Group being launched |
| launchCount | input | 10 | Number of threads in the group |
| launchError | output | 1 | Previous launch was refused |
| arriveValid | input | 1 | A thread reached a barrier this cycle |
| arriveGroup | input | 1 | Group of the arriving thread |
| arriveThread | input | 9 | Index of the arriving thread inside its group |
| arriveError | output | 1 | Previous arrival was dropped as invalid |
| waitMask | output | 1024 | Waiting bit per thread, bit group*512 + thread |
| releaseValid | output | 1 | One-cycle release pulse |
| releaseGroup | output | 1 | Group released by the pulse |

## Verification
The assertions check a set of properties on every cycle. The number of set waiting bits of a group always equals its arrival count, and the count stays below the group size. Every release follows an arrival and finds that group's bitmap empty. Duplicate arrivals and zero-size launches always raise their flags. Only the bench's scenarios can show the rest: the release lands on the group and the cycle of the completing arrival, the barrier reuses at once, groups stay separate when their traffic interleaves, launch wins over a colliding arrival, and a 512-thread group needs every one of its threads.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  localparam int unsigned MaxThreads = 512;
  localparam int unsigned NumGroups  = 2;   // power of two, at least 2
  localparam int unsigned TidW = $clog2(MaxThreads);
  localparam int unsigned CntW = $clog2(MaxThreads + 1);
  localparam int unsigned GrpW = $clog2(NumGroups);

  typedef struct packed {
    logic            loadEn;
    logic [GrpW-1:0] loadGrp;
    logic [CntW-1:0] loadSize;
    logic            bumpEn;   // count an arrival and mark it waiting
    logic            fireEn;   // last arrival: clear the group
    logic [GrpW-1:0] arrGrp;
    logic [TidW-1:0] arrTid;
  } barStrobe_t;
endpackage

// File: rtl/barrier_dp.sv
module barrier_dp
  import barrier_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rstN,
  input  barStrobe_t                            strobe,
  output logic [NumGroups-1:0][CntW-1:0]        grpSize,
  output logic [NumGroups-1:0][CntW-1:0]        grpCount,
  output logic [NumGroups-1:0][MaxThreads-1:0]  grpMask
);
  for (genvar g = 0; g < NumGroups; g++) begin : gGroup
    logic [CntW-1:0]       sizeQ;
    logic [CntW-1:0]       cntQ;
    logic [MaxThreads-1:0] maskQ;
    logic loadHit, arrHit;

    assign loadHit = strobe.loadEn && (strobe.loadGrp == GrpW'(g));
    assign arrHit  = strobe.arrGrp == GrpW'(g);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        sizeQ <= '0;
        cntQ  <= '0;
        maskQ <= '0;
      end else if (loadHit) begin
        sizeQ <= strobe.loadSize;
        cntQ  <= '0;
        maskQ <= '0;
      end else if (strobe.fireEn && arrHit) begin
        cntQ  <= '0;
        maskQ <= '0;
      end else if (strobe.bumpEn && arrHit) begin
        cntQ  <= cntQ + CntW'(1);
        maskQ[strobe.arrTid] <= 1'b1;
      end
    end

    assign grpSize[g]  = sizeQ;
    assign grpCount[g] = cntQ;
    assign grpMask[g]  = maskQ;

    assert_mask_matches_count_R4: assert property (@(posedge clk) disable iff (!rstN)
      $countones(maskQ) == int'(cntQ));

    assert_count_below_size_R6: assert property (@(posedge clk) disable iff (!rstN)
      (sizeQ != '0) |-> (cntQ < sizeQ));

    assert_idle_group_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
      (sizeQ == '0) |-> (maskQ == '0));
  end
endmodule

// File: rtl/barrier_ctrl.sv
module barrier_ctrl
  import barrier_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  launchValid,
  input  logic [GrpW-1:0]                       launchGroup,
  input  logic [CntW-1:0]                       launchCount,
  input  logic                                  arriveValid,
  input  logic [GrpW-1:0]                       arriveGroup,
  input  logic [TidW-1:0]                       arriveThread,
  input  logic [NumGroups-1:0][CntW-1:0]        grpSize,
  input  logic [NumGroups-1:0][CntW-1:0]        grpCount,
  input  logic [NumGroups-1:0][MaxThreads-1:0]  grpMask,
  output barStrobe_t                            strobe,
  output logic                                  launchError,
  output logic                                  arriveError,
  output logic                                  releaseValid,
  output logic [GrpW-1:0]                       releaseGroup
);
  logic            launchOk, collide, inRange, isWaiting, arrOk, arrLast, arrBad;
  logic [CntW-1:0] arrSize, arrCnt;

  always_comb begin
    launchOk  = launchValid && (launchCount != '0) && (launchCount <= CntW'(MaxThreads));
    collide   = launchOk && (launchGroup == arriveGroup);
    arrSize   = grpSize[arriveGroup];
    arrCnt    = grpCount[arriveGroup];
    inRange   = (arrSize != '0) && (CntW'(arriveThread) < arrSize);
    isWaiting = inRange && grpMask[arriveGroup][arriveThread];
    arrOk     = arriveValid && !collide && inRange && !isWaiting;
    arrLast   = (arrCnt + CntW'(1)) == arrSize;
    arrBad    = arriveValid && !collide && !arrOk;

    strobe          = '0;
    strobe.loadEn   = launchOk;
    strobe.loadGrp  = launchGroup;
    strobe.loadSize = launchCount;
    strobe.bumpEn   = arrOk && !arrLast;
    strobe.fireEn   = arrOk && arrLast;
    strobe.arrGrp   = arriveGroup;
    strobe.arrTid   = arriveThread;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      launchError  <= 1'b0;
      arriveError  <= 1'b0;
      releaseValid <= 1'b0;
      releaseGroup <= '0;
    end else begin
      launchError  <= launchValid && !launchOk;
      arriveError  <= arrBad;
      releaseValid <= strobe.fireEn;
      if (strobe.fireEn) releaseGroup <= arriveGroup;
    end
  end

  assert_release_follows_arrival_R5: assert property (@(posedge clk) disable iff (!rstN)
    releaseValid |-> $past(arriveValid));

  assert_release_group_empty_R5: assert property (@(posedge clk) disable iff (!rstN)
    releaseValid |-> (grpMask[releaseGroup] == '0));

  assert_duplicate_flagged_R7: assert property (@(posedge clk) disable iff (!rstN)
    (arriveValid && !collide && isWaiting) |=> arriveError);

  assert_zero_launch_rejected_R3: assert property (@(posedge clk) disable iff (!rstN)
    (launchValid && launchCount == '0) |=> launchError);
endmodule

// File: rtl/barrier_unit.sv
module barrier_unit
  import barrier_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            launchValid,
  input  logic [GrpW-1:0]                 launchGroup,
  input  logic [CntW-1:0]                 launchCount,
  output logic                            launchError,
  input  logic                            arriveValid,
  input  logic [GrpW-1:0]                 arriveGroup,
  input  logic [TidW-1:0]                 arriveThread,
  output logic                            arriveError,
  output logic [NumGroups*MaxThreads-1:0] waitMask,
  output logic                            releaseValid,
  output logic [GrpW-1:0]                 releaseGroup
);
  barStrobe_t                           strobe;
  logic [NumGroups-1:0][CntW-1:0]       grpSize;
  logic [NumGroups-1:0][CntW-1:0]       grpCount;
  logic [NumGroups-1:0][MaxThreads-1:0] grpMask;

  barrier_ctrl i_ctrl (
    .clk(clk), .rstN(rstN),
    .launchValid(launchValid), .launchGroup(launchGroup), .launchCount(launchCount),
    .arriveValid(arriveValid), .arriveGroup(arriveGroup), .arriveThread(arriveThread),
    .grpSize(grpSize), .grpCount(grpCount), .grpMask(grpMask),
    .strobe(strobe), .launchError(launchError), .arriveError(arriveError),
    .releaseValid(releaseValid), .releaseGroup(releaseGroup)
  );

  barrier_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .grpSize(grpSize), .grpCount(grpCount), .grpMask(grpMask)
  );

  assign waitMask = grpMask;
endmodule

// File: tb/test_barrier_unit.sv
`timescale 1ns/1ps
module test_barrier_unit;
  import barrier_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic launchValid = 1'b0;
  logic [GrpW-1:0] launchGroup = '0;
  logic [CntW-1:0] launchCount = '0;
  logic launchError;
  logic arriveValid = 1'b0;
  logic [GrpW-1:0] arriveGroup = '0;
  logic [TidW-1:0] arriveThread = '0;
  logic arriveError;
  logic [NumGroups*MaxThreads-1:0] waitMask;
  logic releaseValid;
  logic [GrpW-1:0] releaseGroup;

  always #2 clk = ~clk;

  barrier_unit i_barrier_unit (
    .clk(clk), .rstN(rstN),
    .launchValid(launchValid), .launchGroup(launchGroup), .launchCount(launchCount),
    .launchError(launchError),
    .arriveValid(arriveValid), .arriveGroup(arriveGroup), .arriveThread(arriveThread),
    .arriveError(arriveError), .waitMask(waitMask),
    .releaseValid(releaseValid), .releaseGroup(releaseGroup)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  // reference model built from the requirements
  int unsigned mSize [NumGroups];
  int unsigned mCnt  [NumGroups];
  logic [NumGroups-1:0][MaxThreads-1:0] mWait;
  int expRel[$];

  task automatic check(input string req, input logic [1023:0] act, input logic [1023:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: every release pulse must match the next expected group
  always @(negedge clk) begin
    if (rstN && releaseValid) begin
      tests++;
      if (expRel.size() == 0) begin
        fails++;
        $display("FAIL R5: actual release of group %0d expected none", releaseGroup);
      end else begin
        int g;
        g = expRel.pop_front();
        if (int'(releaseGroup) != g) begin
          fails++;
          $display("FAIL R5: actual release group %0d expected %0d", releaseGroup, g);
        end
      end
    end
  end

  task automatic modelArrive(input int g, input int t, output bit bad);
    bad = !(mSize[g] != 0 && t < int'(mSize[g]) && !mWait[g][t]);
    if (!bad) begin
      if (mCnt[g] + 1 == mSize[g]) begin
        expRel.push_back(g);
        mCnt[g] = 0;
        mWait[g] = '0;
      end else begin
        mCnt[g]++;
        mWait[g][t] = 1'b1;
      end
    end
  endtask

  task automatic arrive(input int g, input int t, input string req);
    bit bad;
    @(negedge clk);
    arriveValid = 1'b1; arriveGroup = GrpW'(g); arriveThread = TidW'(t);
    modelArrive(g, t, bad);
    @(negedge clk);
    arriveValid = 1'b0;
    check({req, " error flag"}, 1024'(arriveError), 1024'(bad));
    check({req, " wait mask"}, 1024'(waitMask), 1024'(mWait));
  endtask

  task automatic launch(input int g, input int n, input string req);
    bit bad;
    @(negedge clk);
    launchValid = 1'b1; launchGroup = GrpW'(g); launchCount = CntW'(n);
    bad = (n == 0) || (n > int'(MaxThreads));
    if (!bad) begin mSize[g] = n; mCnt[g] = 0; mWait[g] = '0; end
    @(negedge clk);
    launchValid = 1'b0;
    check({req, " launch flag"}, 1024'(launchError), 1024'(bad));
    check({req, " wait mask"}, 1024'(waitMask), 1024'(mWait));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < int'(NumGroups); g++) begin mSize[g] = 0; mCnt[g] = 0; end
    mWait = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 wait mask", 1024'(waitMask), '0);
    check("R1 release", 1024'(releaseValid), '0);
    check("R1 errors", 1024'({arriveError, launchError}), '0);
    arrive(0, 0, "R1 R8 unlaunched group");

    // R2 / R4 / R7 / R5 / R6 on group 0, size 4
    launch(0, 4, "R2 launch size 4");
    arrive(0, 0, "R4 first arrival");
    arrive(0, 1, "R4 second arrival");
    arrive(0, 2, "R4 third arrival");
    arrive(0, 1, "R7 duplicate arrival");
    arrive(0, 3, "R5 completing arrival");
    arrive(0, 2, "R6 reuse after release");
    arrive(0, 0, "R6 reuse second");

    // R9 independent groups, R8 out of range thread
    launch(1, 3, "R2 launch group 1");
    arrive(1, 2, "R9 group 1 arrival");
    arrive(0, 3, "R9 group 0 arrival");
    arrive(1, 5, "R8 thread beyond size");
    arrive(1, 0, "R9 group 1 second");
    arrive(0, 1, "R9 group 0 completes");
    arrive(1, 1, "R9 group 1 completes");

    // R3 refused launches leave state alone
    arrive(1, 0, "R3 setup arrival");
    launch(1, 0, "R3 zero size launch");
    launch(1, 513, "R3 oversize launch");
    arrive(1, 0, "R3 state kept duplicate");

    // R10 launch and arrival on the same group together
    @(negedge clk);
    launchValid = 1'b1; launchGroup = '0; launchCount = CntW'(2);
    arriveValid = 1'b1; arriveGroup = '0; arriveThread = TidW'(1);
    mSize[0] = 2; mCnt[0] = 0; mWait[0] = '0;
    @(negedge clk);
    launchValid = 1'b0; arriveValid = 1'b0;
    check("R10 no arrival error", 1024'(arriveError), '0);
    check("R10 no launch error", 1024'(launchError), '0);
    check("R10 wait mask", 1024'(waitMask), 1024'(mWait));
    arrive(0, 1, "R10 fresh round");
    arrive(0, 0, "R10 fresh round completes");

    // size 1 group: back-to-back releases (R5 R6)
    launch(0, 1, "R2 launch size 1");
    @(negedge clk);
    arriveValid = 1'b1; arriveGroup = '0; arriveThread = '0;
    begin bit b; modelArrive(0, 0, b); end
    @(negedge clk);
    begin bit b; modelArrive(0, 0, b); end
    check("R5 size one release", 1024'(releaseValid), 1);
    @(negedge clk);
    arriveValid = 1'b0;
    check("R6 back to back release", 1024'(releaseValid), 1);
    check("R6 mask clear", 1024'(waitMask), 1024'(mWait));
    @(negedge clk);
    check("R5 pulse ends", 1024'(releaseValid), 0);

    // R11 full 512-thread group, reverse order; group 1 round replaced by launch
    launch(1, 512, "R11 launch full group");
    for (int t = 511; t >= 0; t--) arrive(1, t, "R11 full group arrival");

    repeat (3) @(negedge clk);
    check("R5 all releases seen", 1024'(expRel.size()), 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule